// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block turns one user request into the full series of I2C transactions that a remote peripheral expects. A request is a 4-bit code taken on a valid/ready handshake. It can ask for a digit to be shown, a fixed eight-byte pattern to be stored, or that pattern to be read back. The sequencer drives a byte-level I2C master engine one operation at a time: a start with address and direction, a byte write, a byte read with ACK or NACK, or a stop. It waits for the engine to report completion before it issues the next operation.

Every request is wrapped between a transaction that turns the peripheral on and one that turns it off. The read-back path writes the command and the memory address with no stop, then uses a repeated start to read an eight-byte burst. Each byte read is passed out on a one-cycle strobe. If the peripheral NACKs an address or a data byte, the request ends with a stop and a sticky error flag is set. The bus bit rate is set inside the engine. It is carried here only as a parameter.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Every start operation carries the 7-bit target address 0x09 in op_data[7:1] and the direction in op_data[0] (0 write, 1 read). Operation codes on op_kind are 0 start, 1 write byte, 2 read byte and 3 stop.
- R2: A request code of 0 to 9 produces these transactions, each closed by a stop: {start W, 0x06}, then {start W, 0x01, 0x00, code}, then {start W, 0x04}.
- R3: Request code 10 produces {start W, 0x06, stop}, then {start W, 0x02, 0x00, 0x01, 0x02, ..., 0x08, stop}, then {start W, 0x04, stop}.
- R4: Request code 11 produces the following in order: {start W, 0x06, stop}; {start W, 0x0B, 0x00} with no stop; a repeated start R followed by eight reads and a stop; then {start W, 0x04, stop}. op_ack is 1 (ACK) on the first seven reads and 0 (NACK) on the eighth. op_ack is 0 on every operation that is not a read.
- R5: The cycle after the engine completes a read, rd_valid is high for exactly one cycle and rd_data holds the byte the engine returned.
- R6: After reset req_ready is 1. A request code of 0 to 11 that is accepted drops req_ready from the next cycle. req_ready returns to 1 the cycle after the engine completes the request's final stop.
- R7: op_valid is high only while an operation is offered. It holds the operation unchanged until op_ready is seen. The next operation is offered only after eng_done for the current one.
- R8: When the engine completes a start or a write byte with eng_nack high, the sequencer sets err_flag, offers a single stop next and then returns to idle. The rest of the request is skipped.
- R9: err_flag is 0 after reset and is cleared by the next accepted request.
- R10: Request codes 12 to 15 are accepted and clear err_flag. They offer no operation, and req_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_code | input | 4 | 0-9 digit, 10 store pattern, 11 read back, 12-15 reserved |
| op_valid | output | 1 | Operation offered to the engine |
| op_ready | input | 1 | Engine takes the operation |
| op_kind | output | 2 | 0 start, 1 write, 2 read, 3 stop |
| op_data | output | 8 | Address byte for a start, data byte for a write, else 0 |
| op_ack | output | 1 | For a read: 1 ACK, 0 NACK |
| eng_done | input | 1 | Engine finished the operation it took |
| eng_nack | input | 1 | With eng_done on a start or write: peripheral did not acknowledge |
| eng_rdata | input | 8 | With eng_done on a read: received byte |
| rd_valid | output | 1 | Read-back byte strobe |
| rd_data | output | 8 | Read-back byte |
| err_flag | output | 1 | Sticky NACK error |

## Verification
The assertions assume an engine that raises eng_done only while it owns an operation it took, never in the same cycle as the handshake, and that drives eng_nack only together with eng_done. They also assume that requests arrive only through the handshake. The bench engine follows these rules. It throttles op_ready in a fixed pattern and replies after a varying latency of zero to two idle cycles. It injects a NACK only at chosen start or write operations, so every input pattern stays inside the assumed protocol while stalls, repeated starts and aborts are all exercised.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        REQ_DIGIT = 2'd0,
        REQ_FILL  = 2'd1,
        REQ_DUMP  = 2'd2
    } req_kind_t;

    typedef struct packed {
        op_kind_t   kind;
        logic [7:0] data;
        logic       ack;
        logic       last;
    } op_t;

    // peripheral command bytes
    localparam logic [7:0] PCMD_POWER_ON  = 8'h06;
    localparam logic [7:0] PCMD_POWER_OFF = 8'h04;
    localparam logic [7:0] PCMD_SHOW      = 8'h01;
    localparam logic [7:0] PCMD_STORE     = 8'h02;
    localparam logic [7:0] PCMD_FETCH     = 8'h0B;
    localparam logic [7:0] SHOW_PORT      = 8'h00;
    localparam logic [7:0] MEM_BASE       = 8'h00;

    localparam logic [3:0] CODE_FILL = 4'd10;
    localparam logic [3:0] CODE_DUMP = 4'd11;

endpackage

// File: rtl/i2c_seq_script.sv
module i2c_seq_script
    import i2c_seq_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h09,
    parameter int          BURST_LEN  = 8,
    parameter int          STEP_W     = 5
) (
    input  req_kind_t          kind,
    input  logic [3:0]         digit,
    input  logic [STEP_W-1:0]  step,
    output op_t                op
);
    localparam int WRAP_LEN = 3;
    localparam logic [STEP_W-1:0] WRAP_N     = STEP_W'(WRAP_LEN);
    localparam logic [STEP_W-1:0] BODY_DIGIT = STEP_W'(5);
    localparam logic [STEP_W-1:0] BODY_FILL  = STEP_W'(4 + BURST_LEN);
    localparam logic [STEP_W-1:0] BODY_DUMP  = STEP_W'(5 + BURST_LEN);
    localparam logic [STEP_W-1:0] FILL_END   = STEP_W'(3 + BURST_LEN);
    localparam logic [STEP_W-1:0] DUMP_END   = STEP_W'(4 + BURST_LEN);
    localparam logic [STEP_W-1:0] DUMP_LASTB = STEP_W'(3 + BURST_LEN);
    localparam logic [7:0] ADDR_W = {SLAVE_ADDR, 1'b0};
    localparam logic [7:0] ADDR_R = {SLAVE_ADDR, 1'b1};

    logic [STEP_W-1:0] body_len;
    logic [STEP_W-1:0] tail_base;
    logic [STEP_W-1:0] mid;
    logic [STEP_W-1:0] tail;

    always_comb begin
        case (kind)
            REQ_FILL: body_len = BODY_FILL;
            REQ_DUMP: body_len = BODY_DUMP;
            default:  body_len = BODY_DIGIT;
        endcase
        tail_base = WRAP_N + body_len;
        mid       = step - WRAP_N;
        tail      = step - tail_base;
    end

    always_comb begin
        op = '{kind: OP_STOP, data: 8'h00, ack: 1'b0, last: 1'b0};
        if (step < WRAP_N) begin
            // power-on transaction
            case (step)
                STEP_W'(0): op = '{kind: OP_START, data: ADDR_W,        ack: 1'b0, last: 1'b0};
                STEP_W'(1): op = '{kind: OP_WRITE, data: PCMD_POWER_ON, ack: 1'b0, last: 1'b0};
                default:    op = '{kind: OP_STOP,  data: 8'h00,         ack: 1'b0, last: 1'b0};
            endcase
        end else if (step < tail_base) begin
            case (kind)
                REQ_FILL: begin
                    if (mid == STEP_W'(0))
                        op = '{kind: OP_START, data: ADDR_W, ack: 1'b0, last: 1'b0};
                    else if (mid == STEP_W'(1))
                        op = '{kind: OP_WRITE, data: PCMD_STORE, ack: 1'b0, last: 1'b0};
                    else if (mid == STEP_W'(2))
                        op = '{kind: OP_WRITE, data: MEM_BASE, ack: 1'b0, last: 1'b0};
                    else if (mid < FILL_END)
                        op = '{kind: OP_WRITE, data: 8'(mid - STEP_W'(2)), ack: 1'b0, last: 1'b0};
                end
                REQ_DUMP: begin
                    if (mid == STEP_W'(0))
                        op = '{kind: OP_START, data: ADDR_W, ack: 1'b0, last: 1'b0};
                    else if (mid == STEP_W'(1))
                        op = '{kind: OP_WRITE, data: PCMD_FETCH, ack: 1'b0, last: 1'b0};
                    else if (mid == STEP_W'(2))
                        op = '{kind: OP_WRITE, data: MEM_BASE, ack: 1'b0, last: 1'b0};
                    else if (mid == STEP_W'(3))
                        op = '{kind: OP_START, data: ADDR_R, ack: 1'b0, last: 1'b0};
                    else if (mid < DUMP_END)
                        op = '{kind: OP_READ, data: 8'h00, ack: (mid != DUMP_LASTB), last: 1'b0};
                end
                default: begin
                    case (mid)
                        STEP_W'(0): op = '{kind: OP_START, data: ADDR_W,          ack: 1'b0, last: 1'b0};
                        STEP_W'(1): op = '{kind: OP_WRITE, data: PCMD_SHOW,       ack: 1'b0, last: 1'b0};
                        STEP_W'(2): op = '{kind: OP_WRITE, data: SHOW_PORT,       ack: 1'b0, last: 1'b0};
                        STEP_W'(3): op = '{kind: OP_WRITE, data: {4'h0, digit},   ack: 1'b0, last: 1'b0};
                        default:    op = '{kind: OP_STOP,  data: 8'h00,           ack: 1'b0, last: 1'b0};
                    endcase
                end
            endcase
        end else begin
            // power-off transaction
            case (tail)
                STEP_W'(0): op = '{kind: OP_START, data: ADDR_W,         ack: 1'b0, last: 1'b0};
                STEP_W'(1): op = '{kind: OP_WRITE, data: PCMD_POWER_OFF, ack: 1'b0, last: 1'b0};
                default:    op = '{kind: OP_STOP,  data: 8'h00,          ack: 1'b0, last: 1'b1};
            endcase
        end
    end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl
    import i2c_seq_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_code,
    output req_kind_t         seq_kind,
    output logic [3:0]        seq_digit,
    output logic [STEP_W-1:0] seq_step,
    input  op_t               cur_op,
    output logic              op_valid,
    input  logic              op_ready,
    output op_kind_t          op_kind,
    output logic [7:0]        op_data,
    output logic              op_ack,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              err_flag
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT, ST_ABORT, ST_ABWAIT
    } st_t;

    typedef struct packed {
        st_t               st;
        req_kind_t         kind;
        logic [3:0]        digit;
        logic [STEP_W-1:0] step;
        logic              err;
        logic              rdv;
        logic [7:0]        rdata;
    } ctl_t;

    ctl_t s_q, s_d;
    logic nack_hit;

    assign nack_hit = (s_q.st == ST_WAIT) && eng_done && eng_nack &&
                      (cur_op.kind == OP_START || cur_op.kind == OP_WRITE);

    always_comb begin
        s_d     = s_q;
        s_d.rdv = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.err  = 1'b0;
                    s_d.step = '0;
                    if (req_code < CODE_FILL) begin
                        s_d.kind  = REQ_DIGIT;
                        s_d.digit = req_code;
                        s_d.st    = ST_ISSUE;
                    end else if (req_code == CODE_FILL) begin
                        s_d.kind = REQ_FILL;
                        s_d.st   = ST_ISSUE;
                    end else if (req_code == CODE_DUMP) begin
                        s_d.kind = REQ_DUMP;
                        s_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: if (op_ready) s_d.st = ST_WAIT;
            ST_WAIT: begin
                if (eng_done) begin
                    if (cur_op.kind == OP_READ) begin
                        s_d.rdv   = 1'b1;
                        s_d.rdata = eng_rdata;
                    end
                    if (nack_hit) begin
                        s_d.err = 1'b1;
                        s_d.st  = ST_ABORT;
                    end else if (cur_op.last) begin
                        s_d.st = ST_IDLE;
                    end else begin
                        s_d.step = s_q.step + STEP_W'(1);
                        s_d.st   = ST_ISSUE;
                    end
                end
            end
            ST_ABORT:  if (op_ready) s_d.st = ST_ABWAIT;
            ST_ABWAIT: if (eng_done) s_d.st = ST_IDLE;
            default:   s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, kind: REQ_DIGIT, digit: 4'h0, step: '0,
                     err: 1'b0, rdv: 1'b0, rdata: 8'h00};
        end else begin
            s_q <= s_d;
        end
    end

    logic aborting;
    assign aborting  = (s_q.st == ST_ABORT) || (s_q.st == ST_ABWAIT);
    assign req_ready = (s_q.st == ST_IDLE);
    assign op_valid  = (s_q.st == ST_ISSUE) || (s_q.st == ST_ABORT);
    assign op_kind   = aborting ? OP_STOP : cur_op.kind;
    assign op_data   = aborting ? 8'h00   : cur_op.data;
    assign op_ack    = aborting ? 1'b0    : cur_op.ack;
    assign seq_kind  = s_q.kind;
    assign seq_digit = s_q.digit;
    assign seq_step  = s_q.step;
    assign rd_valid  = s_q.rdv;
    assign rd_data   = s_q.rdata;
    assign err_flag  = s_q.err;

    // R6
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_code <= CODE_DUMP) |=> !req_ready);

    // R7
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_kind) && $stable(op_data) && $stable(op_ack)));

    // R7
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready) |=> !op_valid);

    // R5
    rd_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(eng_done) && $past(op_kind) == OP_READ));

    // R8
    nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack_hit |=> (err_flag && op_valid && op_kind == OP_STOP));

    // R9
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !err_flag);

endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
    import i2c_seq_pkg::*;
#(
    parameter int          BIT_RATE_HZ = 50_000,
    parameter logic [6:0]  SLAVE_ADDR  = 7'h09,
    parameter int          BURST_LEN   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [3:0] req_code,
    output logic       op_valid,
    input  logic       op_ready,
    output logic [1:0] op_kind,
    output logic [7:0] op_data,
    output logic       op_ack,
    input  logic       eng_done,
    input  logic       eng_nack,
    input  logic [7:0] eng_rdata,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       err_flag
);
    localparam int MAX_STEPS = 3 + 5 + BURST_LEN + 3;
    localparam int STEP_W    = $clog2(MAX_STEPS + 1);

    if (BIT_RATE_HZ <= 0 || BURST_LEN < 1) begin : g_bad_cfg
        $error("i2c_cmd_seq: invalid configuration");
    end

    req_kind_t         seq_kind;
    logic [3:0]        seq_digit;
    logic [STEP_W-1:0] seq_step;
    op_t               cur_op;
    op_kind_t          kind_e;

    i2c_seq_script #(
        .SLAVE_ADDR (SLAVE_ADDR),
        .BURST_LEN  (BURST_LEN),
        .STEP_W     (STEP_W)
    ) u_script (
        .kind  (seq_kind),
        .digit (seq_digit),
        .step  (seq_step),
        .op    (cur_op)
    );

    i2c_seq_ctrl #(
        .STEP_W (STEP_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_code  (req_code),
        .seq_kind  (seq_kind),
        .seq_digit (seq_digit),
        .seq_step  (seq_step),
        .cur_op    (cur_op),
        .op_valid  (op_valid),
        .op_ready  (op_ready),
        .op_kind   (kind_e),
        .op_data   (op_data),
        .op_ack    (op_ack),
        .eng_done  (eng_done),
        .eng_nack  (eng_nack),
        .eng_rdata (eng_rdata),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .err_flag  (err_flag)
    );

    assign op_kind = kind_e;

    // R1
    start_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0) |-> (op_data[7:1] == SLAVE_ADDR));

    // R4
    ack_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ack) |-> (op_kind == 2'd2));

endmodule

// File: tb/i2c_cmd_seq_tb.sv
`timescale 1ns/1ps
module i2c_cmd_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_code = 4'h0;
    logic       op_valid;
    logic       op_ready = 1'b0;
    logic [1:0] op_kind;
    logic [7:0] op_data;
    logic       op_ack;
    logic       eng_done = 1'b0;
    logic       eng_nack = 1'b0;
    logic [7:0] eng_rdata = 8'h00;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       err_flag;

    always #2.5 clk = ~clk;

    i2c_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .op_valid(op_valid), .op_ready(op_ready),
        .op_kind(op_kind), .op_data(op_data), .op_ack(op_ack),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .err_flag(err_flag)
    );

    typedef struct {
        logic [1:0] k;
        logic [7:0] d;
        logic       a;
    } xop_t;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit wd = 0;

    // reference model state
    xop_t  m_q[$];
    xop_t  m_cur;
    bit    m_busy = 0, m_wait = 0, m_err = 0, m_rdv = 0, r10_pend = 0;
    logic [7:0] m_rdd = 8'h00;
    int    m_lat = 0, op_no = 0, nack_at = -1;
    string cur_tag = "R2";
    logic [3:0] pend_code[$];
    int         pend_nack[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic void push(input logic [1:0] k, input logic [7:0] d, input logic a);
        xop_t o;
        o.k = k; o.d = d; o.a = a;
        m_q.push_back(o);
    endfunction

    // expected operation list from R2, R3, R4 (start=0 write=1 read=2 stop=3)
    function automatic void build(input logic [3:0] code);
        m_q.delete();
        if (code > 4'd11) return;
        push(0, 8'h12, 0); push(1, 8'h06, 0); push(3, 8'h00, 0);
        if (code <= 4'd9) begin
            push(0, 8'h12, 0); push(1, 8'h01, 0); push(1, 8'h00, 0); push(1, {4'h0, code}, 0);
            push(3, 8'h00, 0);
        end else if (code == 4'd10) begin
            push(0, 8'h12, 0); push(1, 8'h02, 0); push(1, 8'h00, 0);
            for (int i = 1; i <= 8; i++) push(1, 8'(i), 0);
            push(3, 8'h00, 0);
        end else begin
            push(0, 8'h12, 0); push(1, 8'h0B, 0); push(1, 8'h00, 0); push(0, 8'h13, 0);
            for (int i = 0; i < 8; i++) push(2, 8'h00, (i < 7));
            push(3, 8'h00, 0);
        end
        push(0, 8'h12, 0); push(1, 8'h04, 0); push(3, 8'h00, 0);
    endfunction

    task automatic tick();
        logic [3:0] code;
        @(negedge clk);
        cyc++;
        // compare with the model
        chk(req_ready === !m_busy, "R6", req_ready, !m_busy);
        chk(op_valid === (m_busy && !m_wait), "R7", op_valid, (m_busy && !m_wait));
        chk(err_flag === m_err, m_err ? "R8" : "R9", err_flag, m_err);
        chk(rd_valid === m_rdv, "R5", rd_valid, m_rdv);
        if (m_rdv) chk(rd_data === m_rdd, "R5", rd_data, m_rdd);
        if (r10_pend) begin
            chk(req_ready && !op_valid && !err_flag, "R10", {req_ready, op_valid, err_flag}, 3'b100);
            r10_pend = 0;
        end
        if (m_busy && !m_wait && op_valid && m_q.size() > 0) begin
            chk(op_kind === m_q[0].k, cur_tag, op_kind, m_q[0].k);
            chk(op_data === m_q[0].d, cur_tag, op_data, m_q[0].d);
            chk(op_ack  === m_q[0].a, cur_tag, op_ack,  m_q[0].a);
            if (m_q[0].k == 2'd0) chk(op_data[7:1] === 7'h09, "R1", op_data[7:1], 7'h09);
        end
        // drive inputs for the next edge
        req_valid = 1'b0; eng_done = 1'b0; eng_nack = 1'b0;
        if (!m_busy && pend_code.size() > 0) begin
            req_valid = 1'b1;
            req_code  = pend_code[0];
        end
        op_ready = ((cyc % 4) != 2);
        if (m_wait && m_lat == 0) begin
            eng_done  = 1'b1;
            eng_nack  = (op_no == nack_at);
            eng_rdata = 8'hA5 ^ 8'(op_no);
        end
        // advance the model across the edge
        m_rdv = 0;
        if (req_valid) begin
            code    = pend_code.pop_front();
            nack_at = pend_nack.pop_front();
            m_err   = 0;
            op_no   = 0;
            build(code);
            cur_tag = (code <= 4'd9) ? "R2" : (code == 4'd10) ? "R3" : "R4";
            if (m_q.size() > 0) m_busy = 1;
            else r10_pend = 1;
        end else if (m_busy && !m_wait) begin
            if (op_ready) begin
                m_cur  = m_q.pop_front();
                m_wait = 1;
                m_lat  = cyc % 3;
            end
        end else if (m_wait) begin
            if (eng_done) begin
                m_wait = 0;
                if (m_cur.k == 2'd2) begin
                    m_rdv = 1;
                    m_rdd = eng_rdata;
                end
                if (eng_nack) begin
                    m_q.delete();
                    push(3, 8'h00, 0);
                    m_err   = 1;
                    cur_tag = "R8";
                    nack_at = -1;
                end
                op_no++;
                if (m_q.size() == 0) m_busy = 0;
            end else begin
                m_lat--;
            end
        end
    endtask

    task automatic queue_req(input logic [3:0] code, input int nk);
        pend_code.push_back(code);
        pend_nack.push_back(nk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        queue_req(4'd3, -1);   // R2
        queue_req(4'd9, -1);   // R2
        queue_req(4'd10, -1);  // R3
        queue_req(4'd11, -1);  // R4, R5
        queue_req(4'd13, -1);  // R10
        queue_req(4'd10, 4);   // R8: NACK on command byte
        queue_req(4'd0, -1);   // R9: error cleared
        queue_req(4'd11, 0);   // R8: address NACK on first start
        queue_req(4'd15, -1);  // R10 after error
        queue_req(4'd11, 6);   // R8: NACK on repeated start
        queue_req(4'd11, -1);  // R4 clean after abort
        tick();
        while ((pend_code.size() > 0 || m_busy) && !wd) begin
            tick();
            if (cyc > 20000) wd = 1;
        end
        if (wd) begin
            checks++;
            errors++;
            $display("FAIL watchdog cycle %0d actual busy expected idle", cyc);
        end else begin
            repeat (4) tick();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule